// File: doc/BRIEF.md
# Switch-Matrix Control Port (I2C Target)

This block is the serial control port of an audio/video switch-matrix device. It oversamples the I2C clock and data lines with the system clock, cleans them with synchronizers and a glitch filter, and recognises START, STOP and repeated START. It answers to a 7-bit address whose upper six bits are fixed at `100100`. The lowest address bit comes from a strap pin, so two devices can share one bus.

A write transfer carries exactly three data bytes. They collect in shadow storage and move to the three live control registers together, and only when the frame closes with STOP or repeated START. Short frames leave the live registers untouched. Surplus bytes get no acknowledge. A read transfer returns two status bytes. These are built from a snapshot of the detector inputs, which is taken when the read address is acknowledged.

Top module: `matrix_ctl_port`

## Requirements
- R1: The port acknowledges an address byte only when its upper seven bits equal `100100` followed by `addrSel` (write 0x90/0x92, read 0x91/0x93). After any other address it drives nothing until the next START.
- R2: After a matching write address, the first three data bytes are each acknowledged. When the frame ends (STOP or repeated START), byte 1 appears on `ctrlA`, byte 2 on `ctrlB` and byte 3 on `ctrlC`.
- R3: A write frame that ends with fewer than three data bytes changes no control output and raises no update strobe.
- R4: A fourth or later data byte gets no acknowledge and is discarded. The first three bytes of that frame still take effect.
- R5: The first byte read is {stsDc[0], stsDc[1], stsDc[2], 0, stsSig[0], stsSig[1], stsSig[2], 0}, sent MSB first.
- R6: The second byte read is {stsLvl[1:0], stsLvl[3:2], stsLvl[5:4], 00}. Every further byte the master acknowledges for reads as 0x00.
- R7: When the master answers a read byte with NACK, the port releases SDA and stays off the bus until the next START.
- R8: The status bytes reflect the inputs at the moment the read address is acknowledged. Later input changes within that transfer do not alter them.
- R9: After reset, all three control outputs are zero, `ctrlUpdate` is low and SDA is released.
- R10: `ctrlUpdate` pulses for exactly one cycle, in the same cycle the committed values appear. The control outputs never change in any other cycle.
- R11: The port changes its SDA drive only while the filtered SCL is low.
- R12: A level change on SCL or SDA that lasts fewer than `FILT_CYC` (default 4) system clocks is ignored. Such a pulse does not disturb an ongoing frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrSel | input | 1 | Strap pin giving address bit 1 of the byte |
| sclIn | input | 1 | I2C clock line as seen at the pad |
| sdaIn | input | 1 | I2C data line as seen at the pad |
| stsDc | input | 3 | DC-level detector flags, channel 1 at bit 0 |
| stsSig | input | 3 | Signal-presence flags, channel 1 at bit 0 |
| stsLvl | input | 6 | Three 2-bit level codes, channel 1 at [1:0] |
| sdaDriveLow | output | 1 | Open-drain drive: 1 pulls SDA low |
| ctrlA | output | 8 | Live control register 1 |
| ctrlB | output | 8 | Live control register 2 |
| ctrlC | output | 8 | Live control register 3 |
| ctrlUpdate | output | 1 | One-cycle strobe marking a commit |

## Verification
Write frames are tried with one to five data bytes, ending with STOP or with repeated START, to foreign and own addresses under both strap settings. This separates full-frame commit from short-frame discard and surplus-byte rejection, and a correct address from a neighbour's. Reads acknowledge past both status bytes, or NACK early and keep clocking. This tells the snapshot apart from live inputs, the zero tail apart from leftover data, and a released line apart from a stuck drive. One frame carries sub-filter pulses on both lines, to show that short spikes neither shift bits nor fake bus conditions.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int FRAME_LEN = 3;
  localparam int STS_BYTES = 2;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_TXACK, ST_SKIP
  } ctlState_t;

  typedef struct packed {
    logic             shiftIn;
    logic             capSts;
    logic             ldShadow;
    logic [SEL_W-1:0] shadowSel;
    logic             commit;
    logic             ldTx;
    logic [SEL_W-1:0] txSel;
    logic             shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/mcp_sync.sv
module mcp_sync #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclF,
  output logic sdaF,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam int LINES = 2;

  logic [LINES-1:0] rawV;
  logic [LINES-1:0] filtV;
  logic sclQ, sdaQ;

  assign rawV = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]    meta;
    logic [CW-1:0] cnt;
    logic          filt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 2'b11;
        cnt  <= '0;
        filt <= 1'b1;
      end else begin
        meta <= {meta[0], rawV[g]};
        if (meta[1] == filt) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
          filt <= meta[1];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filtV[g] = filt;
  end

  assign sclF = filtV[0];
  assign sdaF = filtV[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b100100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       busEvt,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaDriveLow
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  ctlState_t st, stN;
  logic [3:0] bitCnt, bitCntN;
  logic [CNT_W-1:0] byteCnt, byteCntN;
  logic rdMode, rdModeN, wrFrame, wrFrameN, ackOk, ackOkN;
  logic addrHit;

  assign addrHit = (rxByte[7:1] == {DEV_ID, addrSel});

  always_comb begin
    stN      = st;
    bitCntN  = bitCnt;
    byteCntN = byteCnt;
    rdModeN  = rdMode;
    wrFrameN = wrFrame;
    ackOkN   = ackOk;
    strb     = '0;
    if (busEvt) begin
      strb.commit = wrFrame && (byteCnt == CNT_W'(FRAME_LEN));
      stN      = startDet ? ST_ADDR : ST_IDLE;
      bitCntN  = '0;
      byteCntN = '0;
      wrFrameN = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_RX: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (st == ST_ADDR) begin
              if (addrHit) begin
                stN      = ST_ACK;
                rdModeN  = rxByte[0];
                wrFrameN = ~rxByte[0];
                strb.capSts = rxByte[0];
              end else begin
                stN = ST_IDLE;
              end
            end else if (byteCnt < CNT_W'(FRAME_LEN)) begin
              strb.ldShadow  = 1'b1;
              strb.shadowSel = SEL_W'(byteCnt);
              byteCntN = byteCnt + 1'b1;
              stN = ST_ACK;
            end else begin
              stN = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (rdMode) begin
              strb.ldTx  = 1'b1;
              strb.txSel = SEL_W'(byteCnt);
              if (byteCnt < CNT_W'(STS_BYTES)) byteCntN = byteCnt + 1'b1;
              stN = ST_TX;
            end else begin
              stN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stN = ST_TXACK;
              bitCntN = '0;
            end else begin
              strb.shiftTx = 1'b1;
              bitCntN = bitCnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            ackOkN = ~sdaF;
          end else if (sclFall) begin
            if (ackOk) begin
              strb.ldTx  = 1'b1;
              strb.txSel = SEL_W'(byteCnt);
              if (byteCnt < CNT_W'(STS_BYTES)) byteCntN = byteCnt + 1'b1;
              stN = ST_TX;
            end else begin
              stN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      rdMode  <= 1'b0;
      wrFrame <= 1'b0;
      ackOk   <= 1'b0;
    end else begin
      st      <= stN;
      bitCnt  <= bitCntN;
      byteCnt <= byteCntN;
      rdMode  <= rdModeN;
      wrFrame <= wrFrameN;
      ackOk   <= ackOkN;
    end
  end

  assign sdaDriveLow = (st == ST_ACK) || (st == ST_TX && !txBit);
endmodule

// File: rtl/mcp_dpath.sv
module mcp_dpath
  import mcp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic                      sdaF,
  input  logic [2:0]                stsDc,
  input  logic [2:0]                stsSig,
  input  logic [5:0]                stsLvl,
  output logic [7:0]                rxByte,
  output logic                      txBit,
  output logic [FRAME_LEN-1:0][7:0] liveRegs,
  output logic                      ctrlUpdate
);
  logic [7:0] rxSh, txSh, stsHold0, stsHold1;
  logic [FRAME_LEN-1:0][7:0] shadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh       <= '0;
      txSh       <= '0;
      stsHold0   <= '0;
      stsHold1   <= '0;
      shadow     <= '0;
      liveRegs   <= '0;
      ctrlUpdate <= 1'b0;
    end else begin
      if (strb.shiftIn) rxSh <= {rxSh[6:0], sdaF};
      if (strb.ldShadow) begin
        for (int i = 0; i < FRAME_LEN; i++)
          if (strb.shadowSel == SEL_W'(i)) shadow[i] <= rxSh;
      end
      if (strb.commit) liveRegs <= shadow;
      ctrlUpdate <= strb.commit;
      if (strb.capSts) begin
        stsHold0 <= {stsDc[0], stsDc[1], stsDc[2], 1'b0,
                     stsSig[0], stsSig[1], stsSig[2], 1'b0};
        stsHold1 <= {stsLvl[1:0], stsLvl[3:2], stsLvl[5:4], 2'b00};
      end
      if (strb.ldTx) begin
        unique case (strb.txSel)
          SEL_W'(0): txSh <= stsHold0;
          SEL_W'(1): txSh <= stsHold1;
          default:   txSh <= 8'h00;
        endcase
      end else if (strb.shiftTx) begin
        txSh <= {txSh[6:0], 1'b0};
      end
    end
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[7];
endmodule

// File: rtl/matrix_ctl_port.sv
module matrix_ctl_port
  import mcp_pkg::*;
#(
  parameter int         FILT_CYC = 4,
  parameter logic [5:0] DEV_ID   = 6'b100100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] stsDc,
  input  logic [2:0] stsSig,
  input  logic [5:0] stsLvl,
  output logic       sdaDriveLow,
  output logic [7:0] ctrlA,
  output logic [7:0] ctrlB,
  output logic [7:0] ctrlC,
  output logic       ctrlUpdate
);
  logic sclF, sdaF, sclRise, sclFall, startDet, stopDet, busEvt, txBit;
  logic [7:0] rxByte;
  logic [FRAME_LEN-1:0][7:0] liveRegs;
  dpStrobe_t strb;

  assign busEvt = startDet | stopDet;

  mcp_sync #(.FILT_CYC(FILT_CYC)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclF(sclF), .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  mcp_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .busEvt(busEvt), .sdaF(sdaF),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaDriveLow(sdaDriveLow)
  );

  mcp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaF(sdaF), .stsDc(stsDc),
    .stsSig(stsSig), .stsLvl(stsLvl), .rxByte(rxByte), .txBit(txBit),
    .liveRegs(liveRegs), .ctrlUpdate(ctrlUpdate)
  );

  assign ctrlA = liveRegs[0];
  assign ctrlB = liveRegs[1];
  assign ctrlC = liveRegs[2];
endmodule

// File: rtl/matrix_ctl_port_chk.sv
module matrix_ctl_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclF,
  input logic       busEvt,
  input logic       sdaDriveLow,
  input logic [7:0] ctrlA,
  input logic [7:0] ctrlB,
  input logic [7:0] ctrlC,
  input logic       ctrlUpdate
);
  // R10
  upd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlUpdate |=> !ctrlUpdate);

  // R10
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({ctrlA, ctrlB, ctrlC}) |-> ctrlUpdate);

  // R2
  commit_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlUpdate |-> $past(busEvt));

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF)) |-> $stable(sdaDriveLow));

  // R9
  rst_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ({ctrlA, ctrlB, ctrlC} == 24'h0 && !ctrlUpdate && !sdaDriveLow));
endmodule

bind matrix_ctl_port matrix_ctl_port_chk u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .busEvt(busEvt),
  .sdaDriveLow(sdaDriveLow), .ctrlA(ctrlA), .ctrlB(ctrlB), .ctrlC(ctrlC),
  .ctrlUpdate(ctrlUpdate)
);

// File: tb/matrix_ctl_port_tb.sv
`timescale 1ns/1ps
module matrix_ctl_port_tb;
  localparam int H = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic strap = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic [2:0] stsDc = '0;
  logic [2:0] stsSig = '0;
  logic [5:0] stsLvl = '0;
  logic sdaDriveLow, ctrlUpdate;
  logic [7:0] ctrlA, ctrlB, ctrlC;
  logic sdaBus;
  assign sdaBus = !(mSdaLow || sdaDriveLow);

  int nChk = 0, nBad = 0, updSeen = 0, updExp = 0, badChg = 0, badHold = 0;
  logic [23:0] expRegs = '0;
  logic [23:0] prevRegs = '0;
  logic prevDrv = 1'b0, prevScl = 1'b1;

  matrix_ctl_port u_dut (
    .clk(clk), .rstN(rstN), .addrSel(strap), .sclIn(mScl), .sdaIn(sdaBus),
    .stsDc(stsDc), .stsSig(stsSig), .stsLvl(stsLvl),
    .sdaDriveLow(sdaDriveLow), .ctrlA(ctrlA), .ctrlB(ctrlB), .ctrlC(ctrlC),
    .ctrlUpdate(ctrlUpdate)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (ctrlUpdate) updSeen++;
      if ({ctrlC, ctrlB, ctrlA} != prevRegs && !ctrlUpdate) badChg++;
      if (sdaDriveLow != prevDrv && mScl && prevScl) badHold++;
    end
    prevRegs = {ctrlC, ctrlB, ctrlA};
    prevDrv  = sdaDriveLow;
    prevScl  = mScl;
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit addrHit(input logic [7:0] a);
    return a[7:1] == {6'b100100, strap};
  endfunction

  function automatic logic [7:0] stsByte1(input logic [2:0] dc, input logic [2:0] sg);
    return {dc[0], dc[1], dc[2], 1'b0, sg[0], sg[1], sg[2], 1'b0};
  endfunction

  function automatic logic [7:0] stsByte2(input logic [5:0] lv);
    return {lv[1:0], lv[3:2], lv[5:4], 2'b00};
  endfunction

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    waitC(5); mSdaLow = 1'b0;
    waitC(H); mScl = 1'b1;
    waitC(H); mSdaLow = 1'b1;
    waitC(H); mScl = 1'b0;
  endtask

  task automatic busStop();
    waitC(5); mSdaLow = 1'b1;
    waitC(H); mScl = 1'b1;
    waitC(H); mSdaLow = 1'b0;
    waitC(H);
  endtask

  task automatic sendBit(input logic b, input bit g);
    waitC(5); mSdaLow = !b;
    waitC(5);
    if (g) begin mScl = 1'b1; waitC(2); mScl = 1'b0; end
    else waitC(2);
    waitC(H - 12);
    mScl = 1'b1;
    if (g && b) begin
      waitC(H / 2); mSdaLow = 1'b1; waitC(2); mSdaLow = 1'b0; waitC(H / 2 - 2);
    end else begin
      waitC(H);
    end
    mScl = 1'b0;
  endtask

  task automatic recvBit(output logic b);
    waitC(5); mSdaLow = 1'b0;
    waitC(H - 5); mScl = 1'b1;
    waitC(H / 2); b = sdaBus;
    waitC(H / 2); mScl = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, input bit g, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) sendBit(v[i], g);
    recvBit(r);
    ack = !r;
  endtask

  task automatic readByte(output logic [7:0] v, input bit ackIt);
    logic r;
    for (int i = 7; i >= 0; i--) begin recvBit(r); v[i] = r; end
    sendBit(!ackIt, 1'b0);
  endtask

  task automatic doWrite(input logic [7:0] addr, input int n, input logic [39:0] dat,
                         input bit restart, input bit glitch);
    logic ack;
    bit hit;
    string tag;
    hit = addrHit(addr) && !addr[0];
    busStart();
    writeByte(addr, 1'b0, ack);
    checkEq("R1 address ack", 32'(ack), 32'(hit));
    for (int i = 0; i < n; i++) begin
      writeByte(dat[8*i +: 8], glitch && i == 1, ack);
      checkEq(i < 3 ? "R2 data ack" : "R4 surplus byte nack", 32'(ack), 32'(hit && i < 3));
    end
    if (hit && n >= 3) begin expRegs = dat[23:0]; updExp++; end
    if (restart) begin busStart(); waitC(10); busStop(); end
    else busStop();
    waitC(10);
    if (!hit) tag = "R1 foreign frame ignored";
    else if (n < 3) tag = "R3 short frame dropped";
    else if (n > 3) tag = "R4 first three kept";
    else tag = "R2 commit";
    checkEq(tag, 32'({ctrlC, ctrlB, ctrlA}), 32'(expRegs));
    checkEq("R10 update count", 32'(updSeen), 32'(updExp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] e1, e2;
    logic ack;
    void'($urandom(32'd2718));
    waitC(10);
    checkEq("R9 reset regs", 32'({ctrlC, ctrlB, ctrlA}), 32'h0);
    checkEq("R9 reset strobe", 32'(ctrlUpdate), 32'h0);
    rstN = 1'b1;
    waitC(10);
    checkEq("R9 reset sda", 32'(sdaDriveLow), 32'h0);
    checkEq("R9 regs after release", 32'({ctrlC, ctrlB, ctrlA}), 32'h0);

    // R2 basic commit, R3 short frame, R4 surplus, R1 foreign address
    doWrite(8'h90, 3, 40'h00_00_C3_5A_A5, 1'b0, 1'b0);
    doWrite(8'h90, 2, 40'h00_00_00_11_22, 1'b0, 1'b0);
    doWrite(8'h90, 1, 40'h00_00_00_00_33, 1'b1, 1'b0);
    doWrite(8'h90, 5, 40'hEE_DD_0F_F0_81, 1'b0, 1'b0);
    doWrite(8'h92, 3, 40'h00_00_12_34_56, 1'b0, 1'b0);
    doWrite(8'h90, 3, 40'h00_00_77_66_55, 1'b1, 1'b0);

    // R12 sub-filter pulses on both lines during a frame
    doWrite(8'h90, 3, 40'h00_00_FF_FF_FF, 1'b0, 1'b1);
    checkEq("R12 glitch rejected", 32'({ctrlC, ctrlB, ctrlA}), 32'hFFFFFF);

    // R5 R6 R8 read with snapshot, zero tail, release after NACK (R7)
    stsDc = 3'b001; stsSig = 3'b110; stsLvl = 6'b01_11_10;
    e1 = stsByte1(stsDc, stsSig); e2 = stsByte2(stsLvl);
    busStart();
    writeByte(8'h91, 1'b0, ack);
    checkEq("R1 read address ack", 32'(ack), 32'h1);
    stsDc = 3'b110; stsSig = 3'b001; stsLvl = 6'b10_00_01;
    readByte(v, 1'b1);
    checkEq("R5 status byte 1", 32'(v), 32'(e1));
    checkEq("R8 snapshot byte 1", 32'(v == stsByte1(stsDc, stsSig)), 32'h0);
    readByte(v, 1'b1);
    checkEq("R6 status byte 2", 32'(v), 32'(e2));
    checkEq("R8 snapshot byte 2", 32'(v == stsByte2(stsLvl)), 32'h0);
    readByte(v, 1'b0);
    checkEq("R6 tail byte", 32'(v), 32'h00);
    waitC(10);
    checkEq("R7 released after nack", 32'(sdaDriveLow), 32'h0);
    readByte(v, 1'b0);
    checkEq("R7 off bus after nack", 32'(v), 32'hFF);
    busStop();

    // R7 early NACK after byte 1, fresh snapshot (R5)
    e1 = stsByte1(stsDc, stsSig);
    busStart();
    writeByte(8'h91, 1'b0, ack);
    readByte(v, 1'b0);
    checkEq("R5 status byte 1 second read", 32'(v), 32'(e1));
    readByte(v, 1'b0);
    checkEq("R7 early nack releases", 32'(v), 32'hFF);
    busStop();

    // R1 strap set: 0x92 owns, 0x90 and 0x91 foreign
    waitC(10);
    strap = 1'b1;
    doWrite(8'h92, 3, 40'h00_00_9C_3E_01, 1'b0, 1'b0);
    doWrite(8'h90, 3, 40'h00_00_44_44_44, 1'b0, 1'b0);
    busStart();
    writeByte(8'h91, 1'b0, ack);
    checkEq("R1 foreign read nack", 32'(ack), 32'h0);
    readByte(v, 1'b0);
    checkEq("R1 foreign read off bus", 32'(v), 32'hFF);
    busStop();
    e2 = stsByte2(stsLvl);
    busStart();
    writeByte(8'h93, 1'b0, ack);
    checkEq("R1 own read ack", 32'(ack), 32'h1);
    readByte(v, 1'b1);
    readByte(v, 1'b0);
    checkEq("R6 status byte 2 strap", 32'(v), 32'(e2));
    busStop();
    strap = 1'b0;

    // random frames
    for (int k = 0; k < 16; k++) begin
      int n, sel;
      logic [7:0] a;
      n = int'($urandom_range(5, 1));
      sel = int'($urandom_range(3, 0));
      a = (sel == 1) ? 8'h92 : 8'h90;
      doWrite(a, n, {$urandom, $urandom}, 1'($urandom_range(1, 0)), 1'b0);
    end

    checkEq("R10 no change without strobe", 32'(badChg), 32'h0);
    checkEq("R11 sda changes only with scl low", 32'(badHold), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule